// File: doc/BRIEF.md
# Low-Power Mode and Power-Domain Sequencer

This block moves a wireless microcontroller between four operating states and drives the power-domain enables that each state needs. The four states are active, CPU doze, sleep and deep sleep. Software picks a target state with a mode command. Two configuration bits travel with the command. One asks for the RAM contents to be retained in sleep. The other asks for the wake timer and slow oscillator island to stay powered in sleep. The interrupt line, radio activity, analog peripheral enables and wake events then decide when the block leaves the state it is in.

Doze stops only the CPU clock. The digital domain, the RAM and the radio stay up, and any interrupt returns the block to active. Sleep and deep sleep both switch the digital domain off. Before that happens, the block holds in active until the radio is idle. Sleep keeps whatever software asked to retain. Deep sleep keeps only the always-on supply logic, which lies outside this block. On wake-up the digital domain is powered first. A one-cycle reset-release pulse for that domain follows, and only then is the CPU clock enabled again.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the state report is 00 (active). `dig_en`, `ram_en`, `island_en` and `cpu_clk_en` are 1, and `dig_rst_rel` is 0.
- R2: In active, a valid command with code 01 (doze) moves the block to doze on the next cycle. Doze reports 01, has `cpu_clk_en` at 0, and keeps `dig_en` and `ram_en` at 1.
- R3: In doze, an asserted `irq` returns the block to active (report 00, `cpu_clk_en` 1) on the next cycle.
- R4: In active, code 10 (sleep) or 11 (deep sleep) is accepted and the block then waits. While `radio_txrx` or any `analog_en` bit is high, it stays in a drain phase that reports 00 with the digital domain and CPU clock on. The cycle after both are sampled low, it enters the target state.
- R5: Sleep reports 10 with `dig_en`, `cpu_clk_en` and `radio_en` at 0. `ram_en` equals the retention bit captured when the command was accepted. `island_en` equals the captured island bit.
- R6: Deep sleep reports 11 with `dig_en`, `ram_en`, `island_en`, `radio_en` and `cpu_clk_en` all 0, whatever the captured configuration bits are.
- R7: Sleep is left when any `wake_pin` bit is high, or when `wake_tmr_exp` is high and the island was kept. Deep sleep is left only by a `wake_pin` bit, so timer expiry there has no effect.
- R8: The cycle after a wake event, `dig_en` and `ram_en` are 1 with `dig_rst_rel` 0 and the report 00. On the next cycle `dig_rst_rel` is 1 for exactly one cycle. On the cycle after that the block is active with `cpu_clk_en` 1.
- R9: Commands are ignored in every state other than active, including the drain and wake-up phases.
- R10: `radio_en` is 1 when `radio_txrx` or any `analog_en` bit is high, and 0 otherwise. It is forced to 0 in sleep and deep sleep.
- R11: The 2-bit state report is encoded as 00 active, 01 doze, 10 sleep and 11 deep sleep. The drain and wake-up phases report 00.
- R12: The configuration bits are captured only when a sleep or deep-sleep command is accepted. Changing them during sleep does not change `ram_en` or `island_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock from the always-on domain |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Mode command strobe |
| mode_cmd | input | 2 | 00 no-op, 01 doze, 10 sleep, 11 deep sleep |
| cfg_ram_keep | input | 1 | Retain RAM in sleep |
| cfg_island_keep | input | 1 | Keep wake timer and slow oscillator powered in sleep |
| irq | input | 1 | Interrupt request (any source) |
| radio_txrx | input | 1 | Radio transmit or receive in progress |
| analog_en | input | N_ANALOG | Analog peripheral enables (ADC, temperature sensor) |
| wake_tmr_exp | input | 1 | Wake timer expiry |
| wake_pin | input | N_WAKE | External wake events |
| dig_en | output | 1 | Digital logic domain enable |
| ram_en | output | 1 | RAM domain enable |
| island_en | output | 1 | Wake timer and slow oscillator enable |
| radio_en | output | 1 | Radio domain enable |
| cpu_clk_en | output | 1 | CPU clock-gate enable |
| dig_rst_rel | output | 1 | One-cycle reset-release pulse for the digital domain |
| state_o | output | 2 | Current state report |

## Verification
Every register in the sequencer surfaces within one clock at `state_o` or at a domain enable. A wrong state decode shows up on the next cycle as a report or enable that disagrees with the reference. A captured configuration bit that is lost or re-sampled appears at `ram_en` or `island_en` once sleep is entered, and is tested by changing the bits mid-sleep. Drain and wake-up timing errors show up as a one-cycle shift of the sleep entry or of the release pulse. The bench compares every output on every clock, so such a shift is caught on the cycle it happens.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

   typedef enum logic [2:0] {
      ST_ACT   = 3'd0,
      ST_DOZE  = 3'd1,
      ST_DRAIN = 3'd2,
      ST_SLEEP = 3'd3,
      ST_DEEP  = 3'd4,
      ST_WUP   = 3'd5,
      ST_WREL  = 3'd6
   } pmc_st_e;

   localparam logic [1:0] CMD_STAY  = 2'b00;
   localparam logic [1:0] CMD_DOZE  = 2'b01;
   localparam logic [1:0] CMD_SLEEP = 2'b10;
   localparam logic [1:0] CMD_DEEP  = 2'b11;

   localparam logic [1:0] RPT_ACT   = 2'b00;
   localparam logic [1:0] RPT_DOZE  = 2'b01;
   localparam logic [1:0] RPT_SLEEP = 2'b10;
   localparam logic [1:0] RPT_DEEP  = 2'b11;

   function automatic logic [1:0] st_report(pmc_st_e s);
      case (s)
         ST_DOZE:  return RPT_DOZE;
         ST_SLEEP: return RPT_SLEEP;
         ST_DEEP:  return RPT_DEEP;
         default:  return RPT_ACT;
      endcase
   endfunction

endpackage

// File: rtl/pmc_cfg_hold.sv
module pmc_cfg_hold #(
   parameter int W = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cap,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (cap) q <= d;
   end
endmodule

// File: rtl/pmc_seq.sv
module pmc_seq
   import pmc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_valid,
   input  logic [1:0] mode_cmd,
   input  logic       irq,
   input  logic       radio_busy,
   input  logic       wake_ext,
   input  logic       wake_tmr,
   output pmc_st_e    st_q,
   output logic       lp_accept
);
   pmc_st_e st_d;
   logic    deep_tgt_q;

   assign lp_accept = (st_q == ST_ACT) && cmd_valid && mode_cmd[1];

   always_comb begin
      st_d = st_q;
      case (st_q)
         ST_ACT: begin
            if (cmd_valid) begin
               if (mode_cmd == CMD_DOZE) st_d = ST_DOZE;
               else if (mode_cmd[1])     st_d = ST_DRAIN;
            end
         end
         ST_DOZE:  if (irq) st_d = ST_ACT;
         ST_DRAIN: if (!radio_busy) st_d = deep_tgt_q ? ST_DEEP : ST_SLEEP;
         ST_SLEEP: if (wake_ext || wake_tmr) st_d = ST_WUP;
         ST_DEEP:  if (wake_ext) st_d = ST_WUP;
         ST_WUP:   st_d = ST_WREL;
         ST_WREL:  st_d = ST_ACT;
         default:  st_d = ST_ACT;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_ACT;
         deep_tgt_q <= 1'b0;
      end else begin
         st_q <= st_d;
         if (lp_accept) deep_tgt_q <= (mode_cmd == CMD_DEEP);
      end
   end
endmodule

// File: rtl/pmc_dom_map.sv
module pmc_dom_map
   import pmc_pkg::*;
(
   input  pmc_st_e    st,
   input  logic       keep_ram,
   input  logic       keep_island,
   input  logic       radio_req,
   output logic       dig_en,
   output logic       ram_en,
   output logic       island_en,
   output logic       radio_en,
   output logic       cpu_clk_en,
   output logic       dig_rst_rel,
   output logic [1:0] state_o
);
   logic powered_down;

   always_comb begin
      powered_down = (st == ST_SLEEP) || (st == ST_DEEP);
      dig_en       = !powered_down;
      cpu_clk_en   = (st == ST_ACT) || (st == ST_DRAIN);
      dig_rst_rel  = (st == ST_WREL);
      radio_en     = !powered_down && radio_req;
      case (st)
         ST_SLEEP: begin
            ram_en    = keep_ram;
            island_en = keep_island;
         end
         ST_DEEP: begin
            ram_en    = 1'b0;
            island_en = 1'b0;
         end
         default: begin
            ram_en    = 1'b1;
            island_en = 1'b1;
         end
      endcase
      state_o = st_report(st);
   end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
   import pmc_pkg::*;
#(
   parameter int N_ANALOG     = 2,
   parameter int N_WAKE       = 2,
   parameter bit TMR_NEEDS_ISL = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cmd_valid,
   input  logic [1:0]          mode_cmd,
   input  logic                cfg_ram_keep,
   input  logic                cfg_island_keep,
   input  logic                irq,
   input  logic                radio_txrx,
   input  logic [N_ANALOG-1:0] analog_en,
   input  logic                wake_tmr_exp,
   input  logic [N_WAKE-1:0]   wake_pin,
   output logic                dig_en,
   output logic                ram_en,
   output logic                island_en,
   output logic                radio_en,
   output logic                cpu_clk_en,
   output logic                dig_rst_rel,
   output logic [1:0]          state_o
);
   localparam int CFG_W = 2;

   if (N_ANALOG < 1) begin : g_bad_analog
      initial $error("pwr_mode_ctrl: N_ANALOG must be at least 1");
   end
   if (N_WAKE < 1) begin : g_bad_wake
      initial $error("pwr_mode_ctrl: N_WAKE must be at least 1");
   end

   pmc_st_e          st_q;
   logic             lp_accept;
   logic [CFG_W-1:0] cfg_q;
   logic             radio_req;
   logic             wake_ext;
   logic             wake_tmr_eff;

   assign radio_req = radio_txrx || (|analog_en);
   assign wake_ext  = |wake_pin;

   if (TMR_NEEDS_ISL) begin : g_tmr_gated
      assign wake_tmr_eff = wake_tmr_exp && cfg_q[1];
   end else begin : g_tmr_free
      assign wake_tmr_eff = wake_tmr_exp;
   end

   pmc_cfg_hold #(.W(CFG_W)) u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .cap   (lp_accept),
      .d     ({cfg_island_keep, cfg_ram_keep}),
      .q     (cfg_q)
   );

   pmc_seq u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_valid  (cmd_valid),
      .mode_cmd   (mode_cmd),
      .irq        (irq),
      .radio_busy (radio_req),
      .wake_ext   (wake_ext),
      .wake_tmr   (wake_tmr_eff),
      .st_q       (st_q),
      .lp_accept  (lp_accept)
   );

   pmc_dom_map u_map (
      .st          (st_q),
      .keep_ram    (cfg_q[0]),
      .keep_island (cfg_q[1]),
      .radio_req   (radio_req),
      .dig_en      (dig_en),
      .ram_en      (ram_en),
      .island_en   (island_en),
      .radio_en    (radio_en),
      .cpu_clk_en  (cpu_clk_en),
      .dig_rst_rel (dig_rst_rel),
      .state_o     (state_o)
   );
endmodule

// File: rtl/pmc_chk.sv
module pmc_chk
   import pmc_pkg::*;
#(
   parameter int N_ANALOG = 2,
   parameter int N_WAKE   = 2
) (
   input logic                clk,
   input logic                rst_n,
   input pmc_st_e             st,
   input logic                cmd_valid,
   input logic [1:0]          mode_cmd,
   input logic                irq,
   input logic                radio_txrx,
   input logic [N_ANALOG-1:0] analog_en,
   input logic [N_WAKE-1:0]   wake_pin,
   input logic                dig_en,
   input logic                ram_en,
   input logic                island_en,
   input logic                radio_en,
   input logic                cpu_clk_en,
   input logic                dig_rst_rel,
   input logic [1:0]          state_o
);
   p_doze_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_ACT && cmd_valid && mode_cmd == CMD_DOZE) |=> (state_o == RPT_DOZE && !cpu_clk_en && dig_en));

   p_doze_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_DOZE && irq) |=> (state_o == RPT_ACT && cpu_clk_en));

   p_drain_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_DRAIN && (radio_txrx || |analog_en)) |=> (st == ST_DRAIN && dig_en));

   p_sleep_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == RPT_SLEEP) |-> (!dig_en && !cpu_clk_en && !radio_en));

   p_deep_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == RPT_DEEP) |-> (!dig_en && !ram_en && !island_en && !radio_en));

   p_deep_pin_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_DEEP && !(|wake_pin)) |=> (st == ST_DEEP));

   p_rel_after_power_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dig_en) |=> dig_rst_rel);

   p_rel_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      dig_rst_rel |=> (!dig_rst_rel && cpu_clk_en));

   p_doze_cmd_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_DOZE && !irq) |=> (st == ST_DOZE));

   p_cfg_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == RPT_SLEEP && $past(state_o) == RPT_SLEEP) |-> ($stable(ram_en) && $stable(island_en)));
endmodule

bind pwr_mode_ctrl pmc_chk #(.N_ANALOG(N_ANALOG), .N_WAKE(N_WAKE)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .st          (st_q),
   .cmd_valid   (cmd_valid),
   .mode_cmd    (mode_cmd),
   .irq         (irq),
   .radio_txrx  (radio_txrx),
   .analog_en   (analog_en),
   .wake_pin    (wake_pin),
   .dig_en      (dig_en),
   .ram_en      (ram_en),
   .island_en   (island_en),
   .radio_en    (radio_en),
   .cpu_clk_en  (cpu_clk_en),
   .dig_rst_rel (dig_rst_rel),
   .state_o     (state_o)
);

// File: tb/sim_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_mode_ctrl;
   localparam int NA = 2;
   localparam int NW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic [1:0]    mode_cmd = 2'b00;
   logic          cfg_ram_keep = 1'b0;
   logic          cfg_island_keep = 1'b0;
   logic          irq = 1'b0;
   logic          radio_txrx = 1'b0;
   logic [NA-1:0] analog_en = '0;
   logic          wake_tmr_exp = 1'b0;
   logic [NW-1:0] wake_pin = '0;
   logic dig_en, ram_en, island_en, radio_en, cpu_clk_en, dig_rst_rel;
   logic [1:0] state_o;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   pwr_mode_ctrl #(.N_ANALOG(NA), .N_WAKE(NW)) u0 (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .mode_cmd(mode_cmd),
      .cfg_ram_keep(cfg_ram_keep), .cfg_island_keep(cfg_island_keep), .irq(irq),
      .radio_txrx(radio_txrx), .analog_en(analog_en), .wake_tmr_exp(wake_tmr_exp),
      .wake_pin(wake_pin), .dig_en(dig_en), .ram_en(ram_en), .island_en(island_en),
      .radio_en(radio_en), .cpu_clk_en(cpu_clk_en), .dig_rst_rel(dig_rst_rel),
      .state_o(state_o)
   );

   // reference model: mode 0 active, 1 doze, 2 sleep, 3 deep
   int m_mode = 0;
   int m_wake = 0;   // 2: domain powering, 1: release pulse
   bit m_pend = 1'b0;
   int m_tgt = 0;
   bit m_kram = 1'b0;
   bit m_kisl = 1'b0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_mode <= 0; m_wake <= 0; m_pend <= 1'b0; m_tgt <= 0;
         m_kram <= 1'b0; m_kisl <= 1'b0;
      end else if (m_wake != 0) begin
         m_wake <= m_wake - 1;
      end else if (m_mode == 0) begin
         if (m_pend) begin
            if (!radio_txrx && analog_en == '0) begin
               m_mode <= m_tgt;
               m_pend <= 1'b0;
            end
         end else if (cmd_valid && mode_cmd == 2'b01) begin
            m_mode <= 1;
         end else if (cmd_valid && mode_cmd >= 2'b10) begin
            m_pend <= 1'b1;
            m_tgt  <= (mode_cmd == 2'b11) ? 3 : 2;
            m_kram <= cfg_ram_keep;
            m_kisl <= cfg_island_keep;
         end
      end else if (m_mode == 1) begin
         if (irq) m_mode <= 0;
      end else if (m_mode == 2) begin
         if (wake_pin != '0 || (wake_tmr_exp && m_kisl)) begin
            m_mode <= 0; m_wake <= 2;
         end
      end else begin
         if (wake_pin != '0) begin
            m_mode <= 0; m_wake <= 2;
         end
      end
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   // cycle-by-cycle comparison against the model, away from the rising edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         bit down;
         int e_rep;
         down  = (m_wake == 0) && (m_mode >= 2);
         e_rep = (m_wake != 0) ? 0 : m_mode;
         chk("R11", "state_o", state_o, e_rep);
         chk("R2", "cpu_clk_en", cpu_clk_en, (m_wake == 0 && m_mode == 0) ? 1 : 0);
         chk("R5", "dig_en", dig_en, down ? 0 : 1);
         chk("R5", "ram_en", ram_en, down ? ((m_mode == 2 && m_kram) ? 1 : 0) : 1);
         chk("R5", "island_en", island_en, down ? ((m_mode == 2 && m_kisl) ? 1 : 0) : 1);
         chk("R10", "radio_en", radio_en, (!down && (radio_txrx || analog_en != '0)) ? 1 : 0);
         chk("R8", "dig_rst_rel", dig_rst_rel, (m_wake == 1) ? 1 : 0);
      end
   end

   task automatic tick(input int n = 1);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #2;
      end
   endtask

   task automatic send(input logic [1:0] c);
      cmd_valid = 1'b1; mode_cmd = c;
      tick();
      cmd_valid = 1'b0; mode_cmd = 2'b00;
   endtask

   initial begin
      #1000000;
      if (!done) begin
         done = 1'b1;
         total++; bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick();
      // R1 reset state
      chk("R1", "state after reset", state_o, 0);
      chk("R1", "enables after reset", {dig_en, ram_en, island_en, cpu_clk_en, dig_rst_rel}, 5'b11110);

      // R2 / R9 / R3 doze
      send(2'b01);
      chk("R2", "doze report", state_o, 1);
      chk("R2", "doze cpu gated, digital on", {cpu_clk_en, dig_en, ram_en}, 3'b011);
      tick(2);
      send(2'b10);
      chk("R9", "sleep cmd in doze ignored", state_o, 1);
      irq = 1'b1; tick(); irq = 1'b0;
      chk("R3", "irq leaves doze", {state_o, cpu_clk_en}, {2'b00, 1'b1});

      // R10 radio in active
      radio_txrx = 1'b1; #1;
      chk("R10", "radio_en from txrx", radio_en, 1);
      radio_txrx = 1'b0; analog_en = 2'b10; #1;
      chk("R10", "radio_en from analog", radio_en, 1);
      analog_en = '0; #1;
      chk("R10", "radio_en idle", radio_en, 0);

      // R4 drain then sleep with retention and island
      cfg_ram_keep = 1'b1; cfg_island_keep = 1'b1; radio_txrx = 1'b1;
      send(2'b10);
      chk("R4", "drain reports active", {state_o, dig_en, cpu_clk_en}, {2'b00, 2'b11});
      tick(2);
      chk("R4", "still draining on txrx", state_o, 0);
      radio_txrx = 1'b0; analog_en = 2'b01;
      tick();
      chk("R4", "still draining on analog", state_o, 0);
      send(2'b01);
      chk("R9", "doze cmd in drain ignored", state_o, 0);
      analog_en = '0;
      tick();
      chk("R4", "sleep entered after idle", state_o, 2);
      chk("R5", "sleep retained domains", {dig_en, ram_en, island_en}, 3'b011);
      cfg_ram_keep = 1'b0; cfg_island_keep = 1'b0;
      tick();
      chk("R12", "cfg change in sleep ignored", {ram_en, island_en}, 2'b11);
      send(2'b01);
      chk("R9", "doze cmd in sleep ignored", state_o, 2);
      radio_txrx = 1'b1; #1;
      chk("R10", "radio forced off in sleep", radio_en, 0);
      radio_txrx = 1'b0;
      wake_tmr_exp = 1'b1; tick(); wake_tmr_exp = 1'b0;
      chk("R7", "timer wakes sleep", state_o, 0);
      chk("R8", "power-up phase", {dig_en, ram_en, dig_rst_rel, cpu_clk_en}, 4'b1100);
      send(2'b01);
      chk("R8", "release pulse", dig_rst_rel, 1);
      chk("R9", "doze cmd in wake-up ignored", state_o, 0);
      tick();
      chk("R8", "active after release", {dig_rst_rel, cpu_clk_en}, 2'b01);
      chk("R9", "no doze after wake-up", state_o, 0);

      // sleep without retention; timer ignored, pin wakes
      send(2'b10);
      tick();
      chk("R5", "sleep without retention", {state_o, ram_en, island_en}, {2'b10, 2'b00});
      wake_tmr_exp = 1'b1; tick(); wake_tmr_exp = 1'b0;
      chk("R7", "timer ignored with island off", state_o, 2);
      wake_pin = 2'b10; tick(); wake_pin = '0;
      chk("R7", "pin wakes sleep", state_o, 0);
      tick(2);

      // deep sleep
      cfg_ram_keep = 1'b1; cfg_island_keep = 1'b1;
      send(2'b11);
      tick();
      chk("R6", "deep report", state_o, 3);
      chk("R6", "deep domains off", {dig_en, ram_en, island_en, cpu_clk_en}, 4'b0000);
      wake_tmr_exp = 1'b1; tick(); wake_tmr_exp = 1'b0;
      chk("R7", "timer ignored in deep", state_o, 3);
      analog_en = 2'b11; #1;
      chk("R10", "radio forced off in deep", radio_en, 0);
      analog_en = '0;
      wake_pin = 2'b01; tick(); wake_pin = '0;
      chk("R7", "pin wakes deep", {state_o, dig_en}, {2'b00, 1'b1});
      tick();
      chk("R8", "release after deep", dig_rst_rel, 1);
      tick(2);
      chk("R11", "back to active", {state_o, cpu_clk_en}, {2'b00, 1'b1});

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule